// File: doc/BRIEF.md
# Host-to-DSP Two-Word Mailbox

This block carries one 31-bit message from a host processor to a DSP. The DSP sees it as two 16-bit read-only registers. The upper word holds a mail-waiting flag in its top bit and message bits 30..16 below it. The lower word holds message bits 15..0.

The host loads the upper half first. That write only fills a holding register. The write of the lower half then commits both halves together and raises the flag. The DSP polls the upper word until the flag reads 1. It then reads the upper word and after that the lower word. Reading the lower word drops the flag, which tells the host it may send the next message.

The flag is also driven onto its own output pin. Other logic can use that pin as a status bit or as an interrupt request toward the DSP.

Top module: `host_to_dsp_mailbox`

## Requirements
- R1: After reset the flag is 0, both committed halves and the holding register are 0, and `mail_pending` is 0.
- R2: A host write with `host_wr_sel`=0 (upper half) stores `host_wr_data[14:0]` in the holding register and ignores bit 15 of the write data. It leaves the flag and the DSP-visible words unchanged.
- R3: A host write with `host_wr_sel`=1 (lower half) commits the holding register as message bits 30..16 and the write data as bits 15..0, both in the same cycle, and sets the flag.
- R4: A DSP read at `HI_ADDR` (default 0xFFFE) returns {flag, message[30:16]} with `dsp_rd_valid`=1 on the cycle after the request. The read has no effect on the flag.
- R5: A DSP read at `LO_ADDR` (default 0xFFFF) returns message[15:0] with `dsp_rd_valid`=1 on the cycle after the request, and clears the flag.
- R6: A DSP read at any other address, and any cycle without a read request, gives `dsp_rd_valid`=0 and `dsp_rd_data`=0. Neither has any effect on the flag.
- R7: A lower-half host write while the flag is already set replaces the whole message, and the flag stays 1.
- R8: When a lower-half host write and a DSP lower-word read fall in the same cycle, the read returns the previous lower word and the flag ends at 1.
- R9: `mail_pending` always equals the flag bit that an upper-word read would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_sel | input | 1 | Half being written: 0 = upper, 1 = lower |
| host_wr_data | input | 16 | Host write data |
| dsp_rd_en | input | 1 | DSP read request |
| dsp_addr | input | 16 | DSP register address |
| dsp_rd_valid | output | 1 | Read data valid, one cycle after a decoded request |
| dsp_rd_data | output | 16 | Read data, zero when not valid |
| mail_pending | output | 1 | Mail-waiting flag, usable as status or interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit halves, a 16-bit DSP address, and the two words at 0xFFFE and 0xFFFF. With these values the upper and lower words are neighbouring addresses at the very top of the address space. Random addresses therefore hit both words and also their near misses, such as 0xFFFD and 0x0000. The random mix also produces collisions between host writes and DSP reads in the same cycle, which exercise the set-over-clear priority and the overwrite of unread mail.

// File: rtl/mbox_pkg.sv
// Package: types shared by the mailbox modules.
// Assumes: the host selects one half per write.
package mbox_pkg;
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_sel_e;
endpackage

// File: rtl/mbox_host_stage.sv
// Module: host-side staging. An upper-half write fills the holding register.
// A lower-half write commits the holding register and the lower data at once.
// Assumes: at most one host write per cycle; bit 15 of upper data is dropped.
module mbox_host_stage
    import mbox_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int UP_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  half_sel_e         wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit,
    output logic [UP_W-1:0]   msg_up,
    output logic [DATA_W-1:0] msg_lo
);
    logic [UP_W-1:0] hold_q;

    // Commit pulse: a lower-half write
    always_comb commit = wr_en && (wr_sel == HALF_LOWER);

    // Holding register: filled by an upper-half write
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_en && wr_sel == HALF_UPPER)
            hold_q <= wr_data[UP_W-1:0];
    end

    // Committed message: both halves updated together on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_up <= '0;
            msg_lo <= '0;
        end else if (commit) begin
            msg_up <= hold_q;
            msg_lo <= wr_data;
        end
    end

    // R2
    upper_write_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == HALF_UPPER) |=> ($stable(msg_up) && $stable(msg_lo)));
    // R3
    lower_write_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (msg_lo == $past(wr_data)));
endmodule

// File: rtl/mbox_addr_decode.sv
// Module: DSP-side address decode for the two mailbox words.
// Assumes: HI_ADDR and LO_ADDR differ.
module mbox_addr_decode #(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'hFFFE,
    parameter logic [ADDR_W-1:0] LO_ADDR = 16'hFFFF
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_up,
    output logic              hit_lo
);
    // Compare the request address with each word address
    always_comb begin
        hit_up = rd_en && (addr == HI_ADDR);
        hit_lo = rd_en && (addr == LO_ADDR);
    end

    // Check at start of simulation that the two addresses differ
    initial begin
        distinct_addr_chk: assert (HI_ADDR != LO_ADDR);
    end
endmodule

// File: rtl/mbox_flag.sv
// Module: mail-waiting flag. Set by a commit, cleared by a lower-word read.
// Set wins over clear in the same cycle, so new mail is never lost.
// Assumes: set and clr are single-cycle strobes.
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/host_to_dsp_mailbox.sv
// Module: top level of the host-to-DSP mailbox. It joins the host staging,
// the DSP address decode and the flag, and registers the DSP read data.
// Assumes: synchronous active-low reset; read data arrives one cycle late.
module host_to_dsp_mailbox
    import mbox_pkg::*;
#(
    parameter int                DATA_W  = 16,
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'hFFFE,
    parameter logic [ADDR_W-1:0] LO_ADDR = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_wr_sel,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              dsp_rd_en,
    input  logic [ADDR_W-1:0] dsp_addr,
    output logic              dsp_rd_valid,
    output logic [DATA_W-1:0] dsp_rd_data,
    output logic              mail_pending
);
    localparam int UP_W = DATA_W - 1;

    half_sel_e         sel;
    logic              commit;
    logic [UP_W-1:0]   msg_up;
    logic [DATA_W-1:0] msg_lo;
    logic              hit_up;
    logic              hit_lo;
    logic              flag;
    logic [DATA_W-1:0] rd_mux;

    // Map the plain select pin onto the shared enum
    always_comb sel = half_sel_e'(host_wr_sel);

    mbox_host_stage #(.DATA_W(DATA_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en),
        .wr_sel  (sel),
        .wr_data (host_wr_data),
        .commit  (commit),
        .msg_up  (msg_up),
        .msg_lo  (msg_lo)
    );

    mbox_addr_decode #(.ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_dec (
        .rd_en  (dsp_rd_en),
        .addr   (dsp_addr),
        .hit_up (hit_up),
        .hit_lo (hit_lo)
    );

    mbox_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (commit),
        .clr   (hit_lo),
        .flag  (flag)
    );

    // Select the word for a decoded read; zero for anything else
    always_comb begin
        if (hit_up)
            rd_mux = {flag, msg_up};
        else if (hit_lo)
            rd_mux = msg_lo;
        else
            rd_mux = '0;
    end

    // Read port register: data and valid one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_rd_valid <= 1'b0;
            dsp_rd_data  <= '0;
        end else begin
            dsp_rd_valid <= hit_up || hit_lo;
            dsp_rd_data  <= rd_mux;
        end
    end

    // Flag pin driven straight from the flag register
    always_comb mail_pending = flag;

    // R4
    upper_read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_up |=> (dsp_rd_valid && dsp_rd_data[DATA_W-1] == $past(flag)));
    // R4
    upper_read_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_up && !commit) |=> (mail_pending == $past(mail_pending)));
    // R6
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_up || hit_lo) |=> (!dsp_rd_valid && dsp_rd_data == '0));
    // R8
    collide_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && hit_lo) |=> mail_pending);
endmodule

// File: tb/tb_host_to_dsp_mailbox.sv
module tb_host_to_dsp_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_wr_sel = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        dsp_rd_en = 1'b0;
    logic [15:0] dsp_addr = '0;
    logic        dsp_rd_valid;
    logic [15:0] dsp_rd_data;
    logic        mail_pending;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state
    bit        m_flag = 1'b0;
    bit [14:0] m_hold = '0;
    bit [14:0] m_up = '0;
    bit [15:0] m_lo = '0;

    always #4 clk = ~clk;

    host_to_dsp_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
        .dsp_rd_en(dsp_rd_en), .dsp_addr(dsp_addr),
        .dsp_rd_valid(dsp_rd_valid), .dsp_rd_data(dsp_rd_data),
        .mail_pending(mail_pending)
    );

    function automatic bit [16:0] expect_read(bit en, bit [15:0] a);
        if (en && a == 16'hFFFE) return {1'b1, m_flag, m_up};
        if (en && a == 16'hFFFF) return {1'b1, m_lo};
        return 17'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, check at the next falling edge
    task automatic step(string req, bit we, bit ws, bit [15:0] wd, bit re, bit [15:0] a);
        bit [16:0] er;
        host_wr_en = we; host_wr_sel = ws; host_wr_data = wd;
        dsp_rd_en = re; dsp_addr = a;
        er = expect_read(re, a);
        if (re && a == 16'hFFFF) m_flag = 1'b0;
        if (we && !ws) m_hold = wd[14:0];
        if (we && ws) begin m_up = m_hold; m_lo = wd; m_flag = 1'b1; end
        @(negedge clk);
        check(req, {15'h0, dsp_rd_valid, dsp_rd_data}, {15'h0, er});
        check("R9", {31'h0, mail_pending}, {31'h0, m_flag});
        host_wr_en = 1'b0; dsp_rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", {31'h0, mail_pending}, 32'h0);
        step("R1", 0, 0, 0, 1, 16'hFFFE);
        step("R1", 0, 0, 0, 1, 16'hFFFF);
        // R2: upper write alone is invisible; bit 15 dropped
        step("R2", 1, 0, 16'hFABC, 0, 0);
        step("R2", 0, 0, 0, 1, 16'hFFFE);
        // R3: lower write commits and sets flag
        step("R3", 1, 1, 16'h1234, 0, 0);
        // R4: upper read, flag unaffected
        step("R4", 0, 0, 0, 1, 16'hFFFE);
        step("R4", 0, 0, 0, 1, 16'hFFFE);
        // R6: other addresses
        step("R6", 0, 0, 0, 1, 16'hFFFD);
        step("R6", 0, 0, 0, 1, 16'h0000);
        // R7: overwrite while pending
        step("R7", 1, 0, 16'h0555, 0, 0);
        step("R7", 1, 1, 16'hBEEF, 0, 0);
        step("R7", 0, 0, 0, 1, 16'hFFFE);
        // R5: lower read clears
        step("R5", 0, 0, 0, 1, 16'hFFFF);
        step("R5", 0, 0, 0, 1, 16'hFFFE);
        // R8: collision of lower write and lower read
        step("R8", 1, 1, 16'hCAFE, 0, 0);
        step("R8", 1, 1, 16'h7777, 1, 16'hFFFF);
        step("R8", 0, 0, 0, 1, 16'hFFFF);
        // Random mix, addresses biased toward the two words
        for (int i = 0; i < 2000; i++) begin
            bit [15:0] a;
            int k;
            k = $urandom_range(0, 3);
            a = (k == 0) ? 16'hFFFE : (k == 1) ? 16'hFFFF :
                (k == 2) ? 16'hFFFD : 16'($urandom);
            step("R4/R5/R7 random", 1'($urandom), 1'($urandom), 16'($urandom),
                 1'($urandom), a);
        end
        // R1: reset in mid-run clears all state
        step("R1", 1, 1, 16'h4242, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_flag = 0; m_hold = 0; m_up = 0; m_lo = 0;
        step("R1", 0, 0, 0, 1, 16'hFFFE);
        step("R1", 0, 0, 0, 1, 16'hFFFF);
        finish_run();
    end
endmodule